// File: doc/BRIEF.md
# Cascaded Interrupt Aggregator with DMA Channel Halt

This block gathers up to 32 interrupt request lines from an I/O controller and presents a single level-sensitive request to one processor interrupt input. Requests come in two kinds. Lines below a fixed boundary index are level requests, and their status follows the peripheral signal with no storage. Lines at or above the boundary are DMA events. Each DMA event sets a sticky status bit that stays set until software clears it.

A constant bit map marks each DMA position as informational or error. An informational event never stalls its channel and can set its bit again as soon as the bit is cleared. An error event drives a halt output to its DMA channel for as long as its status bit is set. The channel therefore cannot raise the event again until software has dealt with it and cleared the bit.

Software uses a small synchronous register port. Address 0 selects the raw status word and address 1 selects the enable mask. A write to the status word clears each DMA bit whose written bit is 0. Read data appears one cycle after the address is presented.

Top module: `irq_aggregator`

## Requirements
- R1: While reset is asserted and after it is released, the mask reads 0, every DMA status bit is 0, no halt output is asserted, the combined output is low, and read data is 0.
- R2: A write with reg_sel_i=1 loads the whole mask word, and a later read with reg_sel_i=1 returns that word.
- R3: A status bit below DMA_BASE (default 16) equals the live req_i bit in every cycle, and a status write cannot clear it, including a write of 0.
- R4: A 1 on a DMA line of req_i for one cycle sets that status bit, and the bit stays set after the request returns to 0.
- R5: A write with reg_sel_i=0 clears each DMA status bit whose reg_wdata_i bit is 0 and leaves every bit whose written value is 1 unchanged.
- R6: When a DMA event and a clear of the same bit fall in the same cycle, the bit ends up set.
- R7: Halt bit j (line DMA_BASE+j) is high exactly while that status bit is set and INFO_MAP bit DMA_BASE+j is 0. With the default INFO_MAP 32'h5555_0000, odd lines 17 to 31 are error events and even lines 16 to 30 never halt.
- R8: irq_o is high exactly while some status bit that is set has its mask bit at 1. Halt outputs do not depend on the mask.
- R9: A status read (reg_sel_i=0) returns the raw status word, with no masking applied.
- R10: Read data is registered. reg_rdata_o holds the selected register's value as it was at the clock edge that sampled reg_sel_i.

Ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_LINES | Level requests (low lines) and DMA event pulses (high lines) |
| reg_sel_i | input | 1 | Register select: 0 status, 1 mask |
| reg_we_i | input | 1 | Write enable |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, one cycle after select |
| halt_o | output | NUM_LINES-DMA_BASE | Per-channel DMA halt |
| irq_o | output | 1 | Combined level request to the processor |

## Verification
On every cycle the assertions check that DMA bits are sticky, that a clear removes only bits with no coincident event, and that an event always lands. They also check that informational channels never halt, that a zero mask keeps irq_o low, that mask writes land, and that read data matches the register selected one edge earlier. The bench scenarios show the rest. These cover level lines that survive a zero write, the mask gating of a single line, raw status readback with the mask closed, and reset taken while a channel is halted.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;
  typedef enum logic { SEL_STATUS = 1'b0, SEL_MASK = 1'b1 } reg_sel_e;
endpackage

// File: rtl/irq_dma_status.sv
module irq_dma_status #(
  parameter int                 NUM_DMA   = 16,
  parameter logic [NUM_DMA-1:0] INFO_BITS = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_DMA-1:0] evt_i,
  input  logic [NUM_DMA-1:0] clr_i,
  output logic [NUM_DMA-1:0] stat_o,
  output logic [NUM_DMA-1:0] halt_o
);
  // event has priority over a clear in the same cycle
  function automatic logic next_bit(input logic cur, input logic evt, input logic clr);
    return evt | (cur & ~clr);
  endfunction

  for (genvar j = 0; j < NUM_DMA; j++) begin : g_ch
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bit_q <= 1'b0;
      else        bit_q <= next_bit(bit_q, evt_i[j], clr_i[j]);
    end
    assign stat_o[j] = bit_q;
    if (INFO_BITS[j]) begin : g_info
      assign halt_o[j] = 1'b0;
    end else begin : g_err
      assign halt_o[j] = bit_q;
    end
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask_o <= '0;
    else if (we_i) mask_o <= wdata_i;
  end
endmodule

// File: rtl/irq_readback.sv
module irq_readback
  import irq_agg_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  reg_sel_e     sel_i,
  input  logic [W-1:0] stat_i,
  input  logic [W-1:0] mask_i,
  output word_t        rdata_o
);
  function automatic word_t pick(input reg_sel_e s, input logic [W-1:0] st, input logic [W-1:0] mk);
    return word_t'((s == SEL_MASK) ? mk : st);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_o <= '0;
    else        rdata_o <= pick(sel_i, stat_i, mask_i);
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int          NUM_LINES = 32,
  parameter int          DMA_BASE  = 16,
  parameter logic [31:0] INFO_MAP  = 32'h5555_0000
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_LINES-1:0]          req_i,
  input  logic                          reg_sel_i,
  input  logic                          reg_we_i,
  input  logic [31:0]                   reg_wdata_i,
  output logic [31:0]                   reg_rdata_o,
  output logic [NUM_LINES-DMA_BASE-1:0] halt_o,
  output logic                          irq_o
);
  localparam int NUM_DMA = NUM_LINES - DMA_BASE;

  reg_sel_e             sel;
  logic                 stat_wr;
  logic                 mask_wr;
  logic [NUM_DMA-1:0]   dma_evt;
  logic [NUM_DMA-1:0]   dma_clr;
  logic [NUM_DMA-1:0]   dma_stat;
  logic [NUM_LINES-1:0] stat_vec;
  logic [NUM_LINES-1:0] mask_q;

  function automatic logic [NUM_DMA-1:0] zero_clear(input logic wr, input logic [NUM_DMA-1:0] wd);
    return wr ? ~wd : '0;
  endfunction

  assign sel      = reg_sel_e'(reg_sel_i);
  assign stat_wr  = reg_we_i && (sel == SEL_STATUS);
  assign mask_wr  = reg_we_i && (sel == SEL_MASK);
  assign dma_evt  = req_i[NUM_LINES-1:DMA_BASE];
  assign dma_clr  = zero_clear(stat_wr, reg_wdata_i[NUM_LINES-1:DMA_BASE]);
  assign stat_vec = {dma_stat, req_i[DMA_BASE-1:0]};
  assign irq_o    = |(stat_vec & mask_q);

  irq_dma_status #(
    .NUM_DMA  (NUM_DMA),
    .INFO_BITS(INFO_MAP[NUM_LINES-1:DMA_BASE])
  ) u_dma (
    .clk   (clk),
    .rst_n (rst_n),
    .evt_i (dma_evt),
    .clr_i (dma_clr),
    .stat_o(dma_stat),
    .halt_o(halt_o)
  );

  irq_mask_reg #(.W(NUM_LINES)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_i   (mask_wr),
    .wdata_i(reg_wdata_i[NUM_LINES-1:0]),
    .mask_o (mask_q)
  );

  irq_readback #(.W(NUM_LINES)) u_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel_i  (sel),
    .stat_i (stat_vec),
    .mask_i (mask_q),
    .rdata_o(reg_rdata_o)
  );
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
  parameter int          NUM_LINES = 32,
  parameter int          DMA_BASE  = 16,
  parameter logic [31:0] INFO_MAP  = 32'h5555_0000
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          we,
  input logic                          sel,
  input logic [31:0]                   wdata,
  input logic [NUM_LINES-DMA_BASE-1:0] dma_evt,
  input logic [NUM_LINES-DMA_BASE-1:0] dma_clr,
  input logic [NUM_LINES-DMA_BASE-1:0] dma_stat,
  input logic [NUM_LINES-1:0]          stat_vec,
  input logic [NUM_LINES-1:0]          mask_q,
  input logic [NUM_LINES-DMA_BASE-1:0] halt_o,
  input logic                          irq_o,
  input logic [31:0]                   rdata
);
  localparam logic [NUM_LINES-DMA_BASE-1:0] INFO_DMA = INFO_MAP[NUM_LINES-1:DMA_BASE];

  a_r4_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((dma_stat & $past(dma_evt)) == $past(dma_evt)));

  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(dma_stat) & ~$past(dma_clr)) & ~dma_stat) == '0));

  a_r5_clears: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((dma_stat & $past(dma_clr) & ~$past(dma_evt)) == '0));

  a_r7_info_no_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_o & INFO_DMA) == '0);

  a_r7_halt_needs_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_o & ~dma_stat) == '0);

  a_r8_closed_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_o);

  a_r2_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel) |=> (mask_q == $past(wdata[NUM_LINES-1:0])));

  a_r10_read_delay: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rdata == 32'($past(sel) ? $past(mask_q) : $past(stat_vec))));
endmodule

bind irq_aggregator irq_aggregator_chk #(
  .NUM_LINES(NUM_LINES),
  .DMA_BASE (DMA_BASE),
  .INFO_MAP (INFO_MAP)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .we      (reg_we_i),
  .sel     (reg_sel_i),
  .wdata   (reg_wdata_i),
  .dma_evt (dma_evt),
  .dma_clr (dma_clr),
  .dma_stat(dma_stat),
  .stat_vec(stat_vec),
  .mask_q  (mask_q),
  .halt_o  (halt_o),
  .irq_o   (irq_o),
  .rdata   (reg_rdata_o)
);

// File: tb/irq_aggregator_tb.sv
`timescale 1ns/1ps
module irq_aggregator_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] req = '0;
  logic        sel = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] halt;
  logic        irq;
  int          n_chk = 0;
  int          n_err = 0;

  always #4 clk = ~clk;

  irq_aggregator u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .reg_sel_i(sel), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .halt_o(halt), .irq_o(irq)
  );

  typedef struct packed {
    logic [31:0] req;
    logic        we;
    logic        sel;
    logic [31:0] wdata;
    logic        exp_irq;
    logic [15:0] exp_halt;
  } vec_t;

  // line 17, 19, 21 are error channels (halt bits 1, 3, 5); 16, 20 informational
  localparam vec_t TBL [14] = '{
    '{32'h0000_0000, 1'b1, 1'b1, 32'hFFFF_FFFF, 1'b0, 16'h0000}, // R2 open mask
    '{32'h0000_0001, 1'b0, 1'b0, 32'h0000_0000, 1'b1, 16'h0000}, // R3 level high
    '{32'h0000_0000, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 16'h0000}, // R3 level low
    '{32'h0002_0000, 1'b0, 1'b0, 32'h0000_0000, 1'b1, 16'h0002}, // R4 error event
    '{32'h0000_0000, 1'b0, 1'b0, 32'h0000_0000, 1'b1, 16'h0002}, // R4 held
    '{32'h0000_0000, 1'b1, 1'b0, 32'hFFFF_FFFF, 1'b1, 16'h0002}, // R5 ones keep
    '{32'h0000_0000, 1'b1, 1'b0, 32'hFFFD_FFFF, 1'b0, 16'h0000}, // R5 zero clears
    '{32'h0001_0000, 1'b0, 1'b0, 32'h0000_0000, 1'b1, 16'h0000}, // R7 info event
    '{32'h0001_0000, 1'b1, 1'b0, 32'hFFFE_FFFF, 1'b1, 16'h0000}, // R6 event wins
    '{32'h0000_0000, 1'b1, 1'b0, 32'hFFFE_FFFF, 1'b0, 16'h0000}, // R5 clear info
    '{32'h0000_0000, 1'b1, 1'b1, 32'h0000_0000, 1'b0, 16'h0000}, // R2 close mask
    '{32'h0008_0001, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 16'h0008}, // R8 masked, halt
    '{32'h0000_0000, 1'b1, 1'b1, 32'h0008_0000, 1'b1, 16'h0008}, // R8 enable 19
    '{32'h0000_0000, 1'b1, 1'b0, 32'h0000_0000, 1'b0, 16'h0000}  // R5 clear all
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] r, input logic w, input logic s, input logic [31:0] d);
    req = r; we = w; sel = s; wdata = d;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    chk("R1 irq in reset", {31'd0, irq}, 32'd0);
    chk("R1 halt in reset", {16'd0, halt}, 32'd0);
    chk("R1 rdata in reset", rdata, 32'd0);
    rst_n = 1'b1;
    drive('0, 1'b0, 1'b1, '0);
    chk("R1 mask after reset", rdata, 32'd0);
    drive('0, 1'b0, 1'b0, '0);
    chk("R1 status after reset", rdata, 32'd0);

    foreach (TBL[i]) begin
      drive(TBL[i].req, TBL[i].we, TBL[i].sel, TBL[i].wdata);
      chk($sformatf("R8 irq row %0d", i), {31'd0, irq}, {31'd0, TBL[i].exp_irq});
      chk($sformatf("R7 halt row %0d", i), {16'd0, halt}, {16'd0, TBL[i].exp_halt});
    end

    // R3: level line survives a zero write; R9: raw readback with bit masked
    drive(32'h0000_0004, 1'b1, 1'b0, 32'h0000_0000);
    chk("R8 masked level", {31'd0, irq}, 32'd0);
    drive(32'h0000_0004, 1'b0, 1'b0, '0);
    chk("R3 R9 status raw", rdata, 32'h0000_0004);

    // R2: mask readback
    drive(32'h0000_0004, 1'b1, 1'b1, 32'h1234_5678);
    drive(32'h0000_0004, 1'b0, 1'b1, '0);
    chk("R2 mask readback", rdata, 32'h1234_5678);
    chk("R8 bit2 still masked", {31'd0, irq}, 32'd0);

    // R10: info event on line 20 appears in status read one cycle later
    drive(32'h0010_0004, 1'b0, 1'b0, '0);
    chk("R10 read before event", rdata, 32'h0000_0004);
    chk("R7 info line 20 no halt", {16'd0, halt}, 32'd0);
    drive(32'h0000_0004, 1'b0, 1'b0, '0);
    chk("R10 read after event", rdata, 32'h0010_0004);

    // R1: reset while error channel 21 halted
    drive(32'h0020_0000, 1'b0, 1'b0, '0);
    chk("R7 halt line 21", {16'd0, halt}, 32'h0000_0020);
    req = '0;
    rst_n = 1'b0;
    #1;
    chk("R1 halt cleared by reset", {16'd0, halt}, 32'd0);
    chk("R1 irq cleared by reset", {31'd0, irq}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    drive('0, 1'b0, 1'b1, '0);
    chk("R1 mask zero after reset", rdata, 32'd0);
    drive('0, 1'b0, 1'b0, '0);
    chk("R1 status zero after reset", rdata, 32'd0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule